// File: doc/BRIEF.md
# FIR Output Destination Router

This block sits behind a filter compute engine and sends each finished FIR result where the running filter instruction says it should go. A destination field comes with every sample. Its path code picks one of three places for the sample:

- back into the engine, to feed a later FIR step;
- down the forward path toward the FIFO, the AGC and the polar converter;
- straight out on a bypass, which also feeds the next channel's FIR.

The field also carries four other controls. The output-strobe bit decides whether the outside world sees a data-ready pulse. The AGC loop-enable and gain-select bits control the AGC. The feedback bit returns converter magnitude and phase to the engine. The step number says which sequencer step takes recirculated or fed-back data.

Loading the output holding register does not depend on the strobe. A cascaded channel can therefore capture a result without telling the outside world. All outputs are registered, so every result appears one clock after the sample is accepted.

Top module: `dest_router`

## Requirements
- R1: While `rst_n` is low at a clock edge, all valid flags, `data_rdy`, `agc_upd`, `agc_gain`, `path_err` and `hold_data` become 0 at that edge.
- R2: The destination field is packed as follows: bit 10 is gain select, bit 9 is AGC loop enable, bits 8:7 are the path code, bit 6 is the output strobe, bit 5 is feedback, and bits 4:0 are the step. A valid sample with path 00 sets `eng_valid` one cycle later, with `eng_data` equal to the sample and `eng_step` equal to the step.
- R3: A valid sample with path 01 sets `fwd_valid` one cycle later, with `fwd_data` equal to the sample.
- R4: A valid sample with path 10 sets `byp_valid` one cycle later, with `byp_data` equal to the sample.
- R5: A valid sample with path 11 produces no `eng_valid`, `fwd_valid`, `byp_valid` or `data_rdy`. Instead it raises `path_err` for one cycle.
- R6: A valid sample with path 01 or 10 is written into `hold_data` one cycle later, whatever the strobe bit is. With any other input, `hold_data` keeps its value.
- R7: `data_rdy` is high for the cycle after a valid sample that has path 01 or 10 and the strobe bit set. In every other case it is low.
- R8: `agc_upd` is high one cycle after a valid sample that has loop enable set and path 01. At that point `agc_mag` holds the absolute value of the two's-complement sample (the most negative value gives 2^(W-1)).
- R9: `agc_gain` equals the gain-select bit only in a cycle where `agc_upd` is high. Otherwise it is 0.
- R10: A valid sample with the feedback bit set raises `fb_valid` one cycle later. At that point `fb_mag` and `fb_phase` hold the converter inputs, and `fb_step` holds the step.
- R11: While `in_valid` is low, no valid flag, `data_rdy`, `agc_upd` or `path_err` is raised in the next cycle, and `hold_data` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Sample present this cycle |
| in_data | input | DATA_W | FIR output sample, two's complement |
| dest | input | 11 | Destination field of the instruction |
| conv_mag | input | DATA_W | Converter magnitude, for feedback |
| conv_phase | input | DATA_W | Converter phase, for feedback |
| eng_valid | output | 1 | Recirculation to the engine is valid |
| eng_data | output | DATA_W | Recirculated sample |
| eng_step | output | 5 | Step that receives the recirculated sample |
| fwd_valid | output | 1 | Forward (FIFO/AGC) path is valid |
| fwd_data | output | DATA_W | Forward sample |
| byp_valid | output | 1 | Bypass output and next-channel feed are valid |
| byp_data | output | DATA_W | Bypass sample |
| hold_data | output | DATA_W | Output holding register |
| data_rdy | output | 1 | One-cycle data-ready strobe |
| agc_upd | output | 1 | AGC loop update request |
| agc_gain | output | 1 | AGC loop gain select |
| agc_mag | output | DATA_W | Magnitude used for the AGC update |
| fb_valid | output | 1 | Feedback to the engine is valid |
| fb_mag | output | DATA_W | Fed-back magnitude |
| fb_phase | output | DATA_W | Fed-back phase |
| fb_step | output | 5 | Step that receives the feedback |
| path_err | output | 1 | Reserved path code seen |

## Verification
The bench targets four kinds of mistakes.

- **Strobe clear on paths 01 and 10.** A design that tied holding-register loading to the strobe would leave `hold_data` stale. One that ignored the strobe would pulse `data_rdy`.
- **Loop enable set on paths 00 and 10.** A design that did not gate AGC updates by path would issue spurious `agc_upd`.
- **Reserved code 11 and idle cycles.** A sloppy decode would leak a valid flag or overwrite the holding register.
- **The most negative sample.** This catches a magnitude that saturates or sign-extends wrongly.

// File: rtl/dest_router_pkg.sv
// Shared types for the FIR output destination router.
// Assumes the destination field is 11 bits, packed as in dest_t (MSB first).
package dest_router_pkg;

    typedef enum logic [1:0] {
        PATH_RECIRC = 2'b00,
        PATH_FWD    = 2'b01,
        PATH_BYPASS = 2'b10,
        PATH_RSVD   = 2'b11
    } path_e;

    typedef struct packed {
        logic       gain_sel;
        logic       loop_en;
        path_e      path;
        logic       strobe;
        logic       fb_en;
        logic [4:0] step;
    } dest_t;

    localparam int DEST_W = $bits(dest_t);
    localparam int STEP_W = 5;

endpackage

// File: rtl/dest_decode.sv
// Combinational decode of the destination field into routing enables.
// Assumes in_valid qualifies every enable; nothing here is registered.
module dest_decode
    import dest_router_pkg::*;
(
    input  logic  in_valid,
    input  dest_t dest,
    output logic  to_eng,
    output logic  to_fwd,
    output logic  to_byp,
    output logic  rsvd,
    output logic  ld_hold,
    output logic  rdy,
    output logic  agc_go,
    output logic  agc_g,
    output logic  fb_go
);

    // Path steering, output-section enables and AGC/feedback gating.
    always_comb begin
        to_eng = 1'b0;
        to_fwd = 1'b0;
        to_byp = 1'b0;
        rsvd   = 1'b0;
        if (in_valid) begin
            unique case (dest.path)
                PATH_RECIRC: to_eng = 1'b1;
                PATH_FWD:    to_fwd = 1'b1;
                PATH_BYPASS: to_byp = 1'b1;
                PATH_RSVD:   rsvd   = 1'b1;
            endcase
        end
        ld_hold = to_fwd | to_byp;
        rdy     = ld_hold & dest.strobe;
        agc_go  = to_fwd & dest.loop_en;
        agc_g   = agc_go & dest.gain_sel;
        fb_go   = in_valid & dest.fb_en;
    end

endmodule

// File: rtl/dest_hold.sv
// Output holding register: captures a sample on load, otherwise keeps its value.
// Assumes synchronous active-low reset clears it to zero.
module dest_hold #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld,
    input  logic [DATA_W-1:0] d,
    output logic [DATA_W-1:0] q
);

    // Load on request, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (ld) q <= d;
    end

    // R6: without a load the register must keep its value.
    p_hold_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ld |=> $stable(q));

endmodule

// File: rtl/dest_router.sv
// FIR output destination router: registers each sample onto the path named by
// its destination field, loads the holding register and issues strobes.
// Assumes one sample per cycle at most and that the converter inputs are valid
// in the same cycle as a sample that carries the feedback bit.
module dest_router
    import dest_router_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic [DEST_W-1:0] dest,
    input  logic [DATA_W-1:0] conv_mag,
    input  logic [DATA_W-1:0] conv_phase,
    output logic              eng_valid,
    output logic [DATA_W-1:0] eng_data,
    output logic [STEP_W-1:0] eng_step,
    output logic              fwd_valid,
    output logic [DATA_W-1:0] fwd_data,
    output logic              byp_valid,
    output logic [DATA_W-1:0] byp_data,
    output logic [DATA_W-1:0] hold_data,
    output logic              data_rdy,
    output logic              agc_upd,
    output logic              agc_gain,
    output logic [DATA_W-1:0] agc_mag,
    output logic              fb_valid,
    output logic [DATA_W-1:0] fb_mag,
    output logic [DATA_W-1:0] fb_phase,
    output logic [STEP_W-1:0] fb_step,
    output logic              path_err
);

    dest_t dst;
    logic  to_eng, to_fwd, to_byp, rsvd, ld_hold, rdy, agc_go, agc_g, fb_go;
    logic [DATA_W-1:0] mag_c;

    assign dst = dest_t'(dest);

    dest_decode u_dec (
        .in_valid (in_valid),
        .dest     (dst),
        .to_eng   (to_eng),
        .to_fwd   (to_fwd),
        .to_byp   (to_byp),
        .rsvd     (rsvd),
        .ld_hold  (ld_hold),
        .rdy      (rdy),
        .agc_go   (agc_go),
        .agc_g    (agc_g),
        .fb_go    (fb_go)
    );

    dest_hold #(.DATA_W(DATA_W)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .ld    (ld_hold),
        .d     (in_data),
        .q     (hold_data)
    );

    // Absolute value of the two's-complement sample, for the AGC update.
    always_comb begin
        mag_c = in_data[DATA_W-1] ? (~in_data + 1'b1) : in_data;
    end

    // Register the valid flags and strobes, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eng_valid <= 1'b0;
            fwd_valid <= 1'b0;
            byp_valid <= 1'b0;
            data_rdy  <= 1'b0;
            agc_upd   <= 1'b0;
            agc_gain  <= 1'b0;
            fb_valid  <= 1'b0;
            path_err  <= 1'b0;
        end else begin
            eng_valid <= to_eng;
            fwd_valid <= to_fwd;
            byp_valid <= to_byp;
            data_rdy  <= rdy;
            agc_upd   <= agc_go;
            agc_gain  <= agc_g;
            fb_valid  <= fb_go;
            path_err  <= rsvd;
        end
    end

    // Register the payloads; each is updated only when its path fires.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eng_data <= '0;
            eng_step <= '0;
            fwd_data <= '0;
            byp_data <= '0;
            agc_mag  <= '0;
            fb_mag   <= '0;
            fb_phase <= '0;
            fb_step  <= '0;
        end else begin
            if (to_eng) begin
                eng_data <= in_data;
                eng_step <= dst.step;
            end
            if (to_fwd) fwd_data <= in_data;
            if (to_byp) byp_data <= in_data;
            if (agc_go) agc_mag  <= mag_c;
            if (fb_go) begin
                fb_mag   <= conv_mag;
                fb_phase <= conv_phase;
                fb_step  <= dst.step;
            end
        end
    end

    // R5: at most one destination (or the error) per sample.
    p_one_path_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({eng_valid, fwd_valid, byp_valid, path_err}));

    // R7: the strobe only accompanies a sample reaching the output section.
    p_rdy_output_r7: assert property (@(posedge clk) disable iff (!rst_n)
        data_rdy |-> (fwd_valid || byp_valid));

    // R8: an AGC update only comes with the forward path.
    p_agc_fwd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        agc_upd |-> fwd_valid);

    // R9: the gain select is zero outside an update.
    p_gain_upd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        agc_gain |-> agc_upd);

    // R11: an idle input cycle produces no output event next cycle.
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !(eng_valid || fwd_valid || byp_valid || path_err || fb_valid));

endmodule

// File: tb/dest_router_tb.sv
module dest_router_tb;

    localparam int CLK_PERIOD = 10;
    localparam int W = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          in_valid;
    logic [W-1:0]  in_data;
    logic [10:0]   dest;
    logic [W-1:0]  conv_mag, conv_phase;
    logic          eng_valid, fwd_valid, byp_valid, data_rdy, agc_upd, agc_gain, fb_valid, path_err;
    logic [W-1:0]  eng_data, fwd_data, byp_data, hold_data, agc_mag, fb_mag, fb_phase;
    logic [4:0]    eng_step, fb_step;

    int checks = 0;
    int errors = 0;

    // Reference model state: expected outputs after the next edge.
    logic         x_eng_v, x_fwd_v, x_byp_v, x_rdy, x_agc_u, x_agc_g, x_fb_v, x_err;
    logic [W-1:0] x_eng_d, x_fwd_d, x_byp_d, x_hold, x_agc_m, x_fb_m, x_fb_p;
    logic [4:0]   x_eng_s, x_fb_s;

    always #(CLK_PERIOD/2) clk = ~clk;

    dest_router #(.DATA_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .dest(dest),
        .conv_mag(conv_mag), .conv_phase(conv_phase),
        .eng_valid(eng_valid), .eng_data(eng_data), .eng_step(eng_step),
        .fwd_valid(fwd_valid), .fwd_data(fwd_data),
        .byp_valid(byp_valid), .byp_data(byp_data), .hold_data(hold_data),
        .data_rdy(data_rdy), .agc_upd(agc_upd), .agc_gain(agc_gain), .agc_mag(agc_mag),
        .fb_valid(fb_valid), .fb_mag(fb_mag), .fb_phase(fb_phase), .fb_step(fb_step),
        .path_err(path_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare every output against the model.
    task automatic compare_all();
        chk("R2 eng_valid", eng_valid, x_eng_v);
        chk("R3 fwd_valid", fwd_valid, x_fwd_v);
        chk("R4 byp_valid", byp_valid, x_byp_v);
        chk("R5 path_err",  path_err,  x_err);
        chk("R6 hold_data", hold_data, x_hold);
        chk("R7 data_rdy",  data_rdy,  x_rdy);
        chk("R8 agc_upd",   agc_upd,   x_agc_u);
        chk("R9 agc_gain",  agc_gain,  x_agc_g);
        chk("R10 fb_valid", fb_valid,  x_fb_v);
        if (x_eng_v) begin
            chk("R2 eng_data", eng_data, x_eng_d);
            chk("R2 eng_step", eng_step, x_eng_s);
        end
        if (x_fwd_v) chk("R3 fwd_data", fwd_data, x_fwd_d);
        if (x_byp_v) chk("R4 byp_data", byp_data, x_byp_d);
        if (x_agc_u) chk("R8 agc_mag", agc_mag, x_agc_m);
        if (x_fb_v) begin
            chk("R10 fb_mag",   fb_mag,   x_fb_m);
            chk("R10 fb_phase", fb_phase, x_fb_p);
            chk("R10 fb_step",  fb_step,  x_fb_s);
        end
    endtask

    // Behavioural prediction for the inputs applied now.
    task automatic predict(input logic rst_now);
        int   sv;
        logic [1:0] p;
        logic v;
        p = dest[8:7];
        v = in_valid & !rst_now;
        x_eng_v = v && p == 2'd0;
        x_fwd_v = v && p == 2'd1;
        x_byp_v = v && p == 2'd2;
        x_err   = v && p == 2'd3;
        x_rdy   = (x_fwd_v || x_byp_v) && dest[6];
        x_agc_u = x_fwd_v && dest[9];
        x_agc_g = x_agc_u && dest[10];
        x_fb_v  = v && dest[5];
        if (rst_now) x_hold = '0;
        else if (x_fwd_v || x_byp_v) x_hold = in_data;
        x_eng_d = in_data; x_fwd_d = in_data; x_byp_d = in_data;
        x_eng_s = dest[4:0]; x_fb_s = dest[4:0];
        sv = $signed(in_data);
        if (sv < 0) sv = -sv;
        x_agc_m = sv[W-1:0];
        x_fb_m = conv_mag; x_fb_p = conv_phase;
    endtask

    // Apply one cycle of stimulus at the falling edge, then check the result.
    task automatic step(input logic v, input logic [W-1:0] d, input logic [10:0] f);
        in_valid = v; in_data = d; dest = f;
        conv_mag = W'($urandom); conv_phase = W'($urandom);
        predict(1'b0);
        @(negedge clk);
        compare_all();
    endtask

    function automatic logic [10:0] fld(input logic g, input logic le, input logic [1:0] p,
                                        input logic s, input logic fb, input logic [4:0] st);
        return {g, le, p, s, fb, st};
    endfunction

    initial begin
        rst_n = 1'b0; in_valid = 1'b1; in_data = 16'h1234;
        dest = fld(1, 1, 2'd1, 1, 1, 5'd3); conv_mag = '0; conv_phase = '0;
        x_hold = '0;
        predict(1'b1);
        repeat (3) @(negedge clk);
        // R1: reset state even with a valid sample on the inputs
        compare_all();
        rst_n = 1'b1;
        // R2 recirculation with step
        step(1, 16'hA5A5, fld(0, 0, 2'd0, 1, 0, 5'd17));
        // R3 forward with strobe, AGC update, gain 1
        step(1, 16'h0123, fld(1, 1, 2'd1, 1, 0, 5'd2));
        // R6/R7 forward with strobe clear: hold loads, no ready
        step(1, 16'h7777, fld(0, 0, 2'd1, 0, 0, 5'd0));
        // R4 bypass with strobe
        step(1, 16'h4242, fld(0, 1, 2'd2, 1, 0, 5'd9));
        // R8 loop enable on bypass: no AGC update; strobe clear
        step(1, 16'h5151, fld(1, 1, 2'd2, 0, 0, 5'd9));
        // R5 reserved path with strobe: error, hold kept
        step(1, 16'hDEAD, fld(1, 1, 2'd3, 1, 1, 5'd31));
        // R11 idle cycle with a forward field on the bus
        step(0, 16'hBEEF, fld(1, 1, 2'd1, 1, 1, 5'd4));
        // R8 most negative sample magnitude
        step(1, 16'h8000, fld(0, 1, 2'd1, 1, 0, 5'd0));
        step(1, 16'hFFFF, fld(0, 1, 2'd1, 0, 0, 5'd0));
        // R9 loop enable clear with gain select set
        step(1, 16'h0010, fld(1, 0, 2'd1, 1, 0, 5'd0));
        // R10 feedback on recirculation
        step(1, 16'h0F0F, fld(0, 0, 2'd0, 0, 1, 5'd12));
        // Random mix
        for (int i = 0; i < 600; i++) begin
            step(($urandom % 4) != 0, W'($urandom), 11'($urandom));
        end
        // R1 reset mid-run clears hold
        rst_n = 1'b0;
        in_valid = 1'b1; in_data = 16'h3333; dest = fld(0, 0, 2'd2, 1, 0, 5'd0);
        predict(1'b1);
        @(negedge clk);
        compare_all();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule